// File: doc/BRIEF.md
# Instruction Block Signature Verifier

This block runs alongside instruction fetch and guards against injected code. Each basic block of a trusted program has a 32-bit reference signature, computed when the program is installed and held in a small on-chip table keyed by the block's start address. While the processor fetches a block, the verifier folds every accepted instruction word into a multiple-input signature register (MISR). The register's feedback polynomial comes from a secret key, so only hardware that holds the key can produce a matching signature.

A new-block pulse from the fetch path closes the open block and starts a fresh signature for the next one. The closed block is judged only if at least one instruction-cache miss occurred while it ran. Code that ran only from the cache has already been vetted. If the block is judged, its start address is looked up in the table. A valid entry with a different signature raises a one-cycle violation pulse. No valid entry for the address raises a separate one-cycle no-entry pulse. Either pulse comes out together with the block's start address. Fetch is never stalled.

Top module: `ibsig_verifier`

## Requirements
- R1: For each accepted word `w` (fetch_valid_i high) in an open block, the signature `s` becomes `{s[30:0],1'b0} ^ (s[31] ? (key_i | 32'h1) : 0) ^ w`.
- R2: A block_start_i pulse opens a new block. Its start address is fetch_pc_i in that cycle, and its signature restarts from SEED (default 32'h5A5A_C3C3). A word accepted in that same cycle is the first word of the new block. A block with no accepted word keeps signature SEED.
- R3: Cycles with fetch_valid_i low and no block_start_i leave the signature unchanged, whatever is on fetch_word_i.
- R4: A block is judged only if icache_miss_i was high in at least one cycle from its own start pulse up to, but not including, the next start pulse. A miss in the same cycle as a start pulse belongs to the new block. An unjudged block produces no pulse.
- R5: If a judged block has a valid table entry whose signature differs, viol_o is high for exactly the one cycle after the closing start pulse, with flag_addr_o equal to the block's start address.
- R6: If a judged block's signature equals its entry's signature, neither viol_o nor nomatch_o pulses.
- R7: If no valid entry holds a judged block's start address, nomatch_o pulses for one cycle (same timing as R5) with flag_addr_o set, and viol_o stays low.
- R8: tbl_we_i writes entry tbl_idx_i with address, signature and valid bit, and the write is visible from the next cycle. An entry written with valid 0 never matches. When several valid entries hold the same address, the lowest index is used.
- R9: After reset every table entry is invalid, no block is open and both pulses are low. The first start pulse after reset closes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_i | input | 32 | Secret key that selects the MISR feedback taps |
| fetch_valid_i | input | 1 | An instruction word is accepted this cycle |
| fetch_word_i | input | 32 | Instruction word |
| fetch_pc_i | input | ADDR_W | Fetch address, taken as the block start when block_start_i is high |
| block_start_i | input | 1 | New basic block begins this cycle |
| icache_miss_i | input | 1 | Instruction-cache miss pulse |
| tbl_we_i | input | 1 | Table load strobe |
| tbl_idx_i | input | IDX_W | Table entry index to load |
| tbl_addr_i | input | ADDR_W | Block start address to load |
| tbl_sig_i | input | 32 | Reference signature to load |
| tbl_valid_i | input | 1 | Valid bit to load |
| viol_o | output | 1 | Signature mismatch pulse |
| nomatch_o | output | 1 | No-entry pulse for a judged block |
| flag_addr_o | output | ADDR_W | Start address of the most recently closed block |

## Verification
Blocks are run against table entries that either hold the bench's own MISR result or that result with one bit flipped. A correct design stays silent on the first and pulses on the second, which separates a faulty fold or faulty feedback from a faulty comparison. Each block is run three ways:
- with the miss in the first cycle,
- with the miss mid-block,
- with the miss only in the next block's start cycle, or with no miss at all.

These runs pin down which block a miss belongs to. Stall bubbles carry garbage words, which exposes folding of invalid cycles. An empty block exposes the seed value. Absent entries, entries written invalid and duplicate addresses at two indices test the table lookup and its priority.

// File: rtl/ibsig_pkg.sv
package ibsig_pkg;
  localparam int SIG_W = 32;
  typedef logic [SIG_W-1:0] sig_t;

  // Feedback taps derived from the key; bit 0 forced so feedback never vanishes.
  function automatic sig_t key_taps(input sig_t key);
    return key | sig_t'(1);
  endfunction

  // One MISR step: shift, conditional polynomial feedback, fold in the word.
  function automatic sig_t misr_step(input sig_t s, input sig_t taps, input sig_t w);
    sig_t fb;
    fb = s[SIG_W-1] ? taps : '0;
    return {s[SIG_W-2:0], 1'b0} ^ fb ^ w;
  endfunction
endpackage

// File: rtl/ibsig_track.sv
module ibsig_track
  import ibsig_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [SIG_W-1:0] SEED = 32'h5A5A_C3C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sig_t              taps,
  input  logic              fetch_valid,
  input  sig_t              fetch_word,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              block_start,
  input  logic              icache_miss,
  output logic              close_ev,
  output sig_t              closed_sig,
  output logic [ADDR_W-1:0] closed_start,
  output logic              closed_missed
);
  sig_t              sig_q;
  logic [ADDR_W-1:0] start_q;
  logic              missed_q;
  logic              open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q    <= SEED;
      start_q  <= '0;
      missed_q <= 1'b0;
      open_q   <= 1'b0;
    end else if (block_start) begin
      sig_q    <= fetch_valid ? misr_step(SEED, taps, fetch_word) : SEED;
      start_q  <= fetch_pc;
      missed_q <= icache_miss;
      open_q   <= 1'b1;
    end else begin
      if (fetch_valid && open_q) sig_q <= misr_step(sig_q, taps, fetch_word);
      if (icache_miss) missed_q <= 1'b1;
    end
  end

  assign close_ev      = block_start & open_q;
  assign closed_sig    = sig_q;
  assign closed_start  = start_q;
  assign closed_missed = missed_q;

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !block_start) |=> $stable(sig_q));
  p_seed_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (block_start && !fetch_valid) |=> (sig_q == SEED));
  p_miss_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    icache_miss |=> missed_q);
endmodule

// File: rtl/ibsig_table.sv
module ibsig_table
  import ibsig_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  sig_t              wr_sig,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output sig_t              hit_sig
);
  logic [ADDR_W-1:0] addr_q [ENTRIES];
  sig_t              sig_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        addr_q[g]  <= '0;
        sig_q[g]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= wr_valid;
        addr_q[g]  <= wr_addr;
        sig_q[g]   <= wr_sig;
      end
    end
    assign match[g] = valid_q[g] && (addr_q[g] == look_addr);
  end

  // Lowest index wins among duplicate addresses.
  always_comb begin
    hit     = 1'b0;
    hit_sig = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_sig = sig_q[i];
      end
    end
  end

  p_load_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/ibsig_judge.sv
module ibsig_judge
  import ibsig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_ev,
  input  logic              closed_missed,
  input  sig_t              closed_sig,
  input  logic [ADDR_W-1:0] closed_start,
  input  logic              hit,
  input  sig_t              hit_sig,
  output logic              viol,
  output logic              nomatch,
  output logic [ADDR_W-1:0] flag_addr
);
  logic judged;
  assign judged = close_ev & closed_missed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      nomatch   <= 1'b0;
      flag_addr <= '0;
    end else begin
      viol    <= judged && hit && (hit_sig != closed_sig);
      nomatch <= judged && !hit;
      if (close_ev) flag_addr <= closed_start;
    end
  end

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(viol && nomatch));
  p_pulse_after_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol || nomatch) |-> $past(close_ev && closed_missed));
  p_unjudged_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (close_ev && !closed_missed) |=> !(viol || nomatch));
endmodule

// File: rtl/ibsig_verifier.sv
module ibsig_verifier
  import ibsig_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter logic [SIG_W-1:0] SEED = 32'h5A5A_C3C3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIG_W-1:0]  key_i,
  input  logic              fetch_valid_i,
  input  logic [SIG_W-1:0]  fetch_word_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              block_start_i,
  input  logic              icache_miss_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [SIG_W-1:0]  tbl_sig_i,
  input  logic              tbl_valid_i,
  output logic              viol_o,
  output logic              nomatch_o,
  output logic [ADDR_W-1:0] flag_addr_o
);
  sig_t              taps;
  logic              close_ev;
  sig_t              closed_sig;
  logic [ADDR_W-1:0] closed_start;
  logic              closed_missed;
  logic              hit;
  sig_t              hit_sig;

  assign taps = key_taps(key_i);

  ibsig_track #(.ADDR_W(ADDR_W), .SEED(SEED)) u_track (
    .clk(clk), .rst_n(rst_n), .taps(taps),
    .fetch_valid(fetch_valid_i), .fetch_word(fetch_word_i), .fetch_pc(fetch_pc_i),
    .block_start(block_start_i), .icache_miss(icache_miss_i),
    .close_ev(close_ev), .closed_sig(closed_sig),
    .closed_start(closed_start), .closed_missed(closed_missed)
  );

  ibsig_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we_i), .wr_idx(tbl_idx_i), .wr_addr(tbl_addr_i),
    .wr_sig(tbl_sig_i), .wr_valid(tbl_valid_i),
    .look_addr(closed_start), .hit(hit), .hit_sig(hit_sig)
  );

  ibsig_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk(clk), .rst_n(rst_n),
    .close_ev(close_ev), .closed_missed(closed_missed),
    .closed_sig(closed_sig), .closed_start(closed_start),
    .hit(hit), .hit_sig(hit_sig),
    .viol(viol_o), .nomatch(nomatch_o), .flag_addr(flag_addr_o)
  );

  p_first_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(viol_o || nomatch_o));
endmodule

// File: tb/ibsig_verifier_bench.sv
module ibsig_verifier_bench;
  localparam logic [31:0] KEY  = 32'h04C1_1DB7;
  localparam logic [31:0] SEED = 32'h5A5A_C3C3;
  localparam logic [31:0] A1 = 32'h1000, A2 = 32'h2000, A3 = 32'h3000, A4 = 32'h4000;
  localparam logic [31:0] A5 = 32'h5000, A6 = 32'h6000, A7 = 32'h7000, FILL = 32'hF000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fv = 1'b0, bs = 1'b0, miss = 1'b0;
  logic [31:0] word = '0, pc = '0;
  logic we = 1'b0, tv = 1'b0;
  logic [3:0] tidx = '0;
  logic [31:0] taddr = '0, tsig = '0;
  logic viol, nomatch;
  logic [31:0] faddr;
  int nchk = 0, nfail = 0;
  logic [31:0] ws [8];

  always #5 clk = ~clk;

  ibsig_verifier u_ibsig_verifier (
    .clk(clk), .rst_n(rst_n), .key_i(KEY),
    .fetch_valid_i(fv), .fetch_word_i(word), .fetch_pc_i(pc),
    .block_start_i(bs), .icache_miss_i(miss),
    .tbl_we_i(we), .tbl_idx_i(tidx), .tbl_addr_i(taddr),
    .tbl_sig_i(tsig), .tbl_valid_i(tv),
    .viol_o(viol), .nomatch_o(nomatch), .flag_addr_o(faddr)
  );

  function automatic logic [31:0] model_sig(input int n);
    logic [31:0] s;
    logic carry;
    s = SEED;
    for (int i = 0; i < n; i++) begin
      carry = s[31];
      s = s << 1;
      if (carry) s = s ^ (KEY | 32'h1);
      s = s ^ ws[i];
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic v, input logic [31:0] w,
                       input logic [31:0] p, input logic m);
    @(negedge clk);
    bs = b; fv = v; word = w; pc = p; miss = m; we = 1'b0;
    @(posedge clk);
    #2;
  endtask

  task automatic load(input int idx, input logic [31:0] a, input logic [31:0] s, input logic v);
    @(negedge clk);
    bs = 1'b0; fv = 1'b0; miss = 1'b0;
    we = 1'b1; tidx = 4'(idx); taddr = a; tsig = s; tv = v;
    @(posedge clk);
    #2;
  endtask

  task automatic run_block(input logic [31:0] a, input int n, input int miss_at, input bit bubbles);
    for (int i = 0; i < n; i++) begin
      drive(i == 0, 1'b1, ws[i], a + 32'(4 * i), i == miss_at);
      if (bubbles) drive(1'b0, 1'b0, 32'hDEAD_BEEF ^ 32'(i), a, 1'b0);
    end
  endtask

  task automatic close_check(input string req, input logic [31:0] nxt, input logic nmiss,
                             input logic ev, input logic en, input logic [31:0] ea);
    drive(1'b1, 1'b0, 32'h0, nxt, nmiss);
    chk(req, {31'b0, viol}, {31'b0, ev});
    chk(req, {31'b0, nomatch}, {31'b0, en});
    if (ev || en) chk(req, faddr, ea);
  endtask

  task automatic fill_words(input logic [31:0] base);
    for (int i = 0; i < 8; i++) ws[i] = base * 32'(i + 3) ^ 32'(i << 20);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #2;
    chk("R9", {31'b0, viol}, 32'h0);
    chk("R9", {31'b0, nomatch}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // R9: first start pulse closes nothing, even with a miss
    drive(1'b1, 1'b0, 32'h0, FILL, 1'b1);
    chk("R9", {31'b0, viol | nomatch}, 32'h0);
    // FILL block had a miss; close it: table empty -> nomatch (R9 table invalid)
    close_check("R9", FILL, 1'b0, 1'b0, 1'b1, FILL);
  endtask

  task automatic t_match;
    fill_words(32'h1357_9BDF);
    load(0, A1, model_sig(5), 1'b1);
    run_block(A1, 5, 2, 1'b0);
    close_check("R6", FILL, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_mismatch;
    fill_words(32'h8765_4321);
    load(4, A7, model_sig(6) ^ 32'h1, 1'b1);
    run_block(A7, 6, 3, 1'b0);
    close_check("R5", FILL, 1'b0, 1'b1, 1'b0, A7);
    drive(1'b0, 1'b0, 32'h0, FILL, 1'b0);
    chk("R5", {31'b0, viol}, 32'h0);
  endtask

  task automatic t_nomiss;
    load(1, A2, 32'hBAD0_0001, 1'b1);
    fill_words(32'h2222_1111);
    run_block(A2, 4, -1, 1'b0);
    close_check("R4", FILL, 1'b0, 1'b0, 1'b0, 32'h0);
    run_block(A2, 4, 0, 1'b0);
    close_check("R4", FILL, 1'b0, 1'b1, 1'b0, A2);
  endtask

  task automatic t_boundary;
    fill_words(32'h1357_9BDF);
    run_block(A1, 5, -1, 1'b0);
    // miss with next start belongs to the A2 block, not A1 (R4)
    close_check("R4", A2, 1'b1, 1'b0, 1'b0, 32'h0);
    close_check("R4", FILL, 1'b0, 1'b1, 1'b0, A2);
  endtask

  task automatic t_stall;
    fill_words(32'h1357_9BDF);
    run_block(A1, 5, 4, 1'b1);
    close_check("R3", FILL, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_nomatch;
    fill_words(32'h0F0F_3C3C);
    run_block(A3, 3, 1, 1'b0);
    close_check("R7", FILL, 1'b0, 1'b0, 1'b1, A3);
    load(2, A4, model_sig(3), 1'b0);
    run_block(A4, 3, 0, 1'b0);
    close_check("R8", FILL, 1'b0, 1'b0, 1'b1, A4);
  endtask

  task automatic t_seed;
    load(3, A6, SEED, 1'b1);
    drive(1'b1, 1'b0, 32'hFFFF_0000, A6, 1'b1);
    drive(1'b0, 1'b0, 32'h1234_5678, A6, 1'b0);
    close_check("R2", FILL, 1'b0, 1'b0, 1'b0, 32'h0);
    // one word with the start pulse: signature is one fold of SEED (R1, R2)
    ws[0] = 32'hA5A5_0F0F;
    load(3, A6, model_sig(1), 1'b1);
    drive(1'b1, 1'b1, ws[0], A6, 1'b1);
    close_check("R1", FILL, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_priority;
    fill_words(32'h7777_ABCD);
    load(5, A5, model_sig(4), 1'b1);
    load(9, A5, model_sig(4) ^ 32'h8000_0000, 1'b1);
    run_block(A5, 4, 1, 1'b0);
    close_check("R8", FILL, 1'b0, 1'b0, 1'b0, 32'h0);
    load(5, A5, model_sig(4) ^ 32'h8000_0000, 1'b1);
    load(9, A5, model_sig(4), 1'b1);
    run_block(A5, 4, 1, 1'b0);
    close_check("R8", FILL, 1'b0, 1'b1, 1'b0, A5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_match();
    t_mismatch();
    t_nomiss();
    t_boundary();
    t_stall();
    t_nomatch();
    t_seed();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule